// File: doc/BRIEF.md
# NAND Flash Host Controller (8-bit raw device)

This block sits between a register-mapped processor bus and one raw NAND flash device with an 8-bit data path. Software controls the device through a few write-only ports. Writing a command byte, an address byte or a data byte places a tagged entry in a small write buffer. A sequencer drains that buffer and turns each entry into one strobe cycle on the flash pins. The sequencer drives the latch lines, the write and read strobes and the data bus.

A single-byte read takes two steps. Software first writes any value to a read-request port, which queues a read strobe in the same buffer. When that strobe completes, the byte appears in a read-data register and a sticky flag is raised, which software clears by writing a one. A page transfer streams a whole page of 256 or 512 bytes over a byte handshake and then raises a page-done flag. A separate write pulses a clear line toward an external ECC accumulator.

Register offsets on `reg_addr`: 0 control, 1 buffer status, 2 event flags, 3 event mask, 4 command byte, 5 address byte, 6 write data, 7 read request, 8 read data, 9 page start, 10 ECC clear.

Top module: `nandc_host`

## Requirements
- R1: After reset: `nand_we_n` and `nand_re_n` are high, `nand_cle`, `nand_ale`, `nand_dq_oe` and `irq` are low, `nand_ce_n` is low, buffer status reads 2 (empty=bit1, full=bit0), and event bits 1 and 2 read 0.
- R2: A write to offset 4 produces one strobe cycle with `nand_we_n` low and `nand_cle` high. During that cycle `nand_ale` is low, `nand_dq_oe` is high and `nand_dq_o` carries the written byte, `reg_wdata[7:0]`.
- R3: A write to offset 5 produces one `nand_we_n` cycle with `nand_ale` high, `nand_cle` low and the byte on `nand_dq_o`.
- R4: A write to offset 6 produces one `nand_we_n` cycle with both latch lines low and the byte on `nand_dq_o`.
- R5: Buffered entries reach the pins in write order. The buffer holds 4 entries waiting behind the one being issued. Status bit0 reads 1 while the buffer is full, and a write that arrives while it is full is dropped.
- R6: The write strobe stays low for exactly wr_dly+1 clock cycles, with wr_dly in control bits [11:8]. The read strobe stays low for rd_dly+1 cycles, with rd_dly in control bits [7:4]. Each strobe is followed by at least one high cycle, and the two strobes are never low at the same time.
- R7: A write of any value to offset 7 produces one `nand_re_n` cycle with `nand_dq_oe` low. The byte present on `nand_dq_i` in the last low cycle is then readable at offset 8, and event bit1 (read-ready) is set.
- R8: Event bits 1 and 2 clear only when a 1 is written to them; a written 0 leaves them unchanged. Event bit0 follows `nand_rb` (1 = device ready) one cycle later.
- R9: `irq` is the OR of the event bits ANDed with the mask at offset 3. A zero mask holds `irq` low.
- R10: Writing 2 to offset 9 starts a page write. Each byte is accepted on a clock edge where `pg_in_valid` and `pg_in_ready` are both high, and each produces one `nand_we_n` cycle with both latch lines low. After the last byte, event bit2 (page-done) is set.
- R11: Writing 1 to offset 9 starts a page read of one `nand_re_n` cycle per byte. Each byte leaves in order on `pg_out_data` with a one-cycle `pg_out_valid`, and event bit2 is set at the end. The read-data register and event bit1 are left untouched.
- R12: Control bit0 selects the page length: 0 gives 256 bytes and 1 gives 512 bytes.
- R13: A write to offset 10 raises `ecc_clr` for exactly one cycle, in the cycle after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register offset for write and read |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read data of the addressed register |
| irq | output | 1 | Masked event request |
| ecc_clr | output | 1 | One-cycle clear for the ECC accumulator |
| pg_in_valid | input | 1 | Page-write byte offered |
| pg_in_data | input | 8 | Page-write byte |
| pg_in_ready | output | 1 | Controller can take a page-write byte |
| pg_out_valid | output | 1 | Page-read byte present |
| pg_out_data | output | 8 | Page-read byte |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_o | output | 8 | Data bus out |
| nand_dq_oe | output | 1 | Data bus output enable |
| nand_dq_i | input | 8 | Data bus in |
| nand_rb | input | 1 | Device ready (1) or busy (0) |

## Verification
The hardest state to reach from the ports is a full write buffer with a write still arriving. This happens only when a slow strobe holds the sequencer busy while software writes faster than entries drain. The stimulus sets the write-strobe delay to its maximum and then issues six command writes on consecutive cycles. The sixth write must vanish, while the first five appear on the pins in order. Random rounds of mixed entries with random delays are compared against a pin log of strobe kind, width and byte. A device model returns a computed byte sequence on every read strobe, so both single reads and page reads can be predicted.

// File: rtl/nandc_pkg.sv
package nandc_pkg;

    typedef enum logic [1:0] {
        TAG_CMD   = 2'd0,
        TAG_ADDR  = 2'd1,
        TAG_WDATA = 2'd2,
        TAG_READ  = 2'd3
    } tag_e;

    typedef struct packed {
        tag_e       tag;
        logic [7:0] val;
    } entry_t;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_LOW  = 2'd1,
        SQ_HIGH = 2'd2
    } sq_e;

    localparam logic [3:0] RA_CTRL  = 4'd0;
    localparam logic [3:0] RA_STAT  = 4'd1;
    localparam logic [3:0] RA_EVT   = 4'd2;
    localparam logic [3:0] RA_MASK  = 4'd3;
    localparam logic [3:0] RA_CMD   = 4'd4;
    localparam logic [3:0] RA_ADDR  = 4'd5;
    localparam logic [3:0] RA_WDATA = 4'd6;
    localparam logic [3:0] RA_RDREQ = 4'd7;
    localparam logic [3:0] RA_RDATA = 4'd8;
    localparam logic [3:0] RA_PAGE  = 4'd9;
    localparam logic [3:0] RA_ECC   = 4'd10;

    localparam int EV_READY  = 0;
    localparam int EV_RDRDY  = 1;
    localparam int EV_PGDONE = 2;

    function automatic tag_e tag_of(input logic [3:0] a);
        case (a)
            RA_CMD:   return TAG_CMD;
            RA_ADDR:  return TAG_ADDR;
            RA_WDATA: return TAG_WDATA;
            default:  return TAG_READ;
        endcase
    endfunction

endpackage

// File: rtl/nandc_wbuf.sv
module nandc_wbuf import nandc_pkg::*; #(
    parameter int DEPTH = 4
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   push,
    input  entry_t push_e,
    input  logic   pop,
    output entry_t head,
    output logic   full,
    output logic   empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    entry_t          mem [DEPTH];
    logic [AW-1:0]   wp, rp;
    logic [CW-1:0]   cnt;
    logic            do_push, do_pop;

    assign full    = (cnt == CW'(DEPTH));
    assign empty   = (cnt == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rp];

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) begin
                mem[wp] <= push_e;
                wp      <= nxt(wp);
            end
            if (do_pop) rp <= nxt(rp);
            cnt <= cnt + CW'(do_push) - CW'(do_pop);
        end
    end

    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
        (full && push && !pop) |=> full);
    assert_pop_nonempty_R5: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);

endmodule

// File: rtl/nandc_seq.sv
module nandc_seq import nandc_pkg::*; #(
    parameter int DLY_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  tag_e             kind,
    input  logic [7:0]       byte_i,
    input  logic [DLY_W-1:0] wdly,
    input  logic [DLY_W-1:0] rdly,
    input  logic [7:0]       dq_i,
    output logic             idle,
    output logic             done,
    output logic [7:0]       rbyte,
    output logic             we_n,
    output logic             re_n,
    output logic             cle,
    output logic             ale,
    output logic [7:0]       dq_o,
    output logic             dq_oe
);
    sq_e              st;
    tag_e             kind_q;
    logic [7:0]       byte_q;
    logic [DLY_W-1:0] cnt;
    logic             active, is_rd;

    assign active = (st != SQ_IDLE);
    assign is_rd  = (kind_q == TAG_READ);
    assign idle   = (st == SQ_IDLE);
    assign done   = (st == SQ_HIGH);
    assign we_n   = !((st == SQ_LOW) && !is_rd);
    assign re_n   = !((st == SQ_LOW) && is_rd);
    assign cle    = active && (kind_q == TAG_CMD);
    assign ale    = active && (kind_q == TAG_ADDR);
    assign dq_oe  = active && !is_rd;
    assign dq_o   = byte_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= SQ_IDLE;
            kind_q <= TAG_CMD;
            byte_q <= '0;
            cnt    <= '0;
            rbyte  <= '0;
        end else begin
            case (st)
                SQ_IDLE: if (start) begin
                    st     <= SQ_LOW;
                    kind_q <= kind;
                    byte_q <= byte_i;
                    cnt    <= (kind == TAG_READ) ? rdly : wdly;
                end
                SQ_LOW: begin
                    if (cnt == '0) begin
                        st <= SQ_HIGH;
                        if (is_rd) rbyte <= dq_i;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: st <= SQ_IDLE;
            endcase
        end
    end

    assert_excl_strobe_R6: assert property (@(posedge clk) disable iff (rst)
        !(!we_n && !re_n));
    assert_we_recover_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(we_n) |=> we_n);
    assert_re_recover_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(re_n) |=> re_n);
    assert_latch_excl_R2: assert property (@(posedge clk) disable iff (rst)
        !(cle && ale));

endmodule

// File: rtl/nandc_host.sv
module nandc_host import nandc_pkg::*; #(
    parameter int DW         = 16,
    parameter int DLY_W      = 4,
    parameter int FIFO_DEPTH = 4,
    parameter int PG_SMALL   = 256,
    parameter int PG_LARGE   = 512
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_wr,
    input  logic [3:0]    reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          irq,
    output logic          ecc_clr,
    input  logic          pg_in_valid,
    input  logic [7:0]    pg_in_data,
    output logic          pg_in_ready,
    output logic          pg_out_valid,
    output logic [7:0]    pg_out_data,
    output logic          nand_ce_n,
    output logic          nand_cle,
    output logic          nand_ale,
    output logic          nand_we_n,
    output logic          nand_re_n,
    output logic [7:0]    nand_dq_o,
    output logic          nand_dq_oe,
    input  logic [7:0]    nand_dq_i,
    input  logic          nand_rb
);
    localparam int PCW    = $clog2(PG_LARGE) + 1;
    localparam int RD_LSB = 4;
    localparam int WR_LSB = RD_LSB + DLY_W;

    logic             cfg_big;
    logic [DLY_W-1:0] cfg_rdly, cfg_wdly;
    logic [2:0]       imask, evt;
    logic             rb_q, rd_rdy, pg_done;
    logic [7:0]       rd_byte;
    logic             pg_act, pg_rd;
    logic [PCW-1:0]   pg_cnt, pg_len;
    logic             cur_pg, cur_rd;

    entry_t           push_e, head;
    logic             push, pop, full, empty;
    logic             sq_start, sq_idle, sq_done, job_pg;
    tag_e             job_kind;
    logic [7:0]       job_byte, sq_rbyte;

    assign push        = reg_wr && (reg_addr >= RA_CMD) && (reg_addr <= RA_RDREQ);
    assign push_e.tag  = tag_of(reg_addr);
    assign push_e.val  = reg_wdata[7:0];
    assign pg_len      = cfg_big ? PCW'(PG_LARGE) : PCW'(PG_SMALL);
    assign evt         = {pg_done, rd_rdy, rb_q};
    assign irq         = |(evt & imask);
    assign pg_in_ready = sq_idle && empty && pg_act && !pg_rd;

    nandc_wbuf #(.DEPTH(FIFO_DEPTH)) u_wbuf (
        .clk(clk), .rst(rst), .push(push), .push_e(push_e),
        .pop(pop), .head(head), .full(full), .empty(empty)
    );

    // Buffered entries take priority over page bytes.
    always_comb begin
        sq_start = 1'b0;
        pop      = 1'b0;
        job_pg   = 1'b0;
        job_kind = head.tag;
        job_byte = head.val;
        if (sq_idle) begin
            if (!empty) begin
                sq_start = 1'b1;
                pop      = 1'b1;
            end else if (pg_act && pg_rd) begin
                sq_start = 1'b1;
                job_pg   = 1'b1;
                job_kind = TAG_READ;
                job_byte = '0;
            end else if (pg_in_ready && pg_in_valid) begin
                sq_start = 1'b1;
                job_pg   = 1'b1;
                job_kind = TAG_WDATA;
                job_byte = pg_in_data;
            end
        end
    end

    nandc_seq #(.DLY_W(DLY_W)) u_seq (
        .clk(clk), .rst(rst), .start(sq_start), .kind(job_kind),
        .byte_i(job_byte), .wdly(cfg_wdly), .rdly(cfg_rdly),
        .dq_i(nand_dq_i), .idle(sq_idle), .done(sq_done), .rbyte(sq_rbyte),
        .we_n(nand_we_n), .re_n(nand_re_n), .cle(nand_cle), .ale(nand_ale),
        .dq_o(nand_dq_o), .dq_oe(nand_dq_oe)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_big      <= 1'b0;
            cfg_rdly     <= '0;
            cfg_wdly     <= '0;
            imask        <= '0;
            rb_q         <= 1'b0;
            rd_rdy       <= 1'b0;
            pg_done      <= 1'b0;
            rd_byte      <= '0;
            pg_act       <= 1'b0;
            pg_rd        <= 1'b0;
            pg_cnt       <= '0;
            cur_pg       <= 1'b0;
            cur_rd       <= 1'b0;
            ecc_clr      <= 1'b0;
            pg_out_valid <= 1'b0;
            pg_out_data  <= '0;
            nand_ce_n    <= 1'b1;
        end else begin
            nand_ce_n    <= 1'b0;
            rb_q         <= nand_rb;
            ecc_clr      <= reg_wr && (reg_addr == RA_ECC);
            pg_out_valid <= 1'b0;
            if (reg_wr) begin
                case (reg_addr)
                    RA_CTRL: begin
                        cfg_big  <= reg_wdata[0];
                        cfg_rdly <= reg_wdata[RD_LSB +: DLY_W];
                        cfg_wdly <= reg_wdata[WR_LSB +: DLY_W];
                    end
                    RA_MASK: imask <= reg_wdata[2:0];
                    RA_EVT: begin
                        if (reg_wdata[EV_RDRDY])  rd_rdy  <= 1'b0;
                        if (reg_wdata[EV_PGDONE]) pg_done <= 1'b0;
                    end
                    RA_PAGE: if (!pg_act && (reg_wdata[1:0] == 2'd1 || reg_wdata[1:0] == 2'd2)) begin
                        pg_act <= 1'b1;
                        pg_rd  <= (reg_wdata[1:0] == 2'd1);
                        pg_cnt <= '0;
                    end
                    default: ;
                endcase
            end
            if (sq_start) begin
                cur_pg <= job_pg;
                cur_rd <= (job_kind == TAG_READ);
            end
            if (sq_done) begin
                if (cur_pg) begin
                    if (cur_rd) begin
                        pg_out_valid <= 1'b1;
                        pg_out_data  <= sq_rbyte;
                    end
                    if (pg_cnt == pg_len - 1'b1) begin
                        pg_act  <= 1'b0;
                        pg_cnt  <= '0;
                        pg_done <= 1'b1;
                    end else begin
                        pg_cnt <= pg_cnt + 1'b1;
                    end
                end else if (cur_rd) begin
                    rd_byte <= sq_rbyte;
                    rd_rdy  <= 1'b1;
                end
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RA_CTRL: begin
                reg_rdata[0]                = cfg_big;
                reg_rdata[RD_LSB +: DLY_W]  = cfg_rdly;
                reg_rdata[WR_LSB +: DLY_W]  = cfg_wdly;
            end
            RA_STAT:  reg_rdata[2:0] = {pg_act, empty, full};
            RA_EVT:   reg_rdata[2:0] = evt;
            RA_MASK:  reg_rdata[2:0] = imask;
            RA_RDATA: reg_rdata[7:0] = rd_byte;
            default:  ;
        endcase
    end

    assert_page_done_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(pg_done) |-> $past(pg_act));
    assert_irq_mask_R9: assert property (@(posedge clk) disable iff (rst)
        (imask == 3'b000) |-> !irq);
    assert_ecc_after_write_R13: assert property (@(posedge clk) disable iff (rst)
        $rose(ecc_clr) |-> $past(reg_wr));
    assert_pgout_from_read_R11: assert property (@(posedge clk) disable iff (rst)
        pg_out_valid |-> (pg_act || pg_done));

endmodule

// File: tb/nandc_host_bench.sv
`timescale 1ns/1ps
module nandc_host_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        irq, ecc_clr;
    logic        pg_in_valid = 1'b0;
    logic [7:0]  pg_in_data = '0;
    logic        pg_in_ready, pg_out_valid;
    logic [7:0]  pg_out_data;
    logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
    logic [7:0]  nand_dq_o, nand_dq_i;
    logic        nand_rb = 1'b1;

    always #2.5 clk = ~clk;

    nandc_host u_nandc_host (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .ecc_clr(ecc_clr),
        .pg_in_valid(pg_in_valid), .pg_in_data(pg_in_data), .pg_in_ready(pg_in_ready),
        .pg_out_valid(pg_out_valid), .pg_out_data(pg_out_data),
        .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
        .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_dq_o(nand_dq_o),
        .nand_dq_oe(nand_dq_oe), .nand_dq_i(nand_dq_i), .nand_rb(nand_rb)
    );

    int nchk = 0;
    int nerr = 0;

    function automatic logic [7:0] dev_byte(input int i);
        return 8'((i * 37 + 11) & 255);
    endfunction
    function automatic logic [7:0] feed_byte(input int i);
        return 8'((i * 53 + 3) & 255);
    endfunction

    // pin log: kind 0 cmd, 1 addr, 2 data write, 3 read
    int         ev_n = 0;
    int         ev_kind [4096];
    int         ev_w    [4096];
    int         ev_dq   [4096];
    int         ev_oe   [4096];
    int         low_cnt = 0;
    int         cur_kind = 0;
    int         cur_dq = 0;
    int         cur_oe = 0;
    int         rd_idx = 0;
    int         pg_n = 0;
    int         pg_dat [1024];

    assign nand_dq_i = dev_byte(rd_idx);

    always @(negedge clk) begin
        if (!nand_we_n || !nand_re_n) begin
            low_cnt++;
            cur_kind = !nand_re_n ? 3 : (nand_cle ? 0 : (nand_ale ? 1 : 2));
            cur_dq   = int'(nand_dq_o);
            cur_oe   = int'(nand_dq_oe);
        end else if (low_cnt > 0) begin
            if (ev_n < 4096) begin
                ev_kind[ev_n] = cur_kind;
                ev_w[ev_n]    = low_cnt;
                ev_dq[ev_n]   = cur_dq;
                ev_oe[ev_n]   = cur_oe;
            end
            ev_n++;
            if (cur_kind == 3) rd_idx++;
            low_cnt = 0;
        end
        if (pg_out_valid) begin
            if (pg_n < 1024) pg_dat[pg_n] = int'(pg_out_data);
            pg_n++;
        end
    end

    // page-write byte source
    bit pg_feed = 1'b0;
    bit acc_pend = 1'b0;
    int wr_idx = 0;
    always @(negedge clk) begin
        if (acc_pend) wr_idx++;
        pg_in_valid = pg_feed;
        pg_in_data  = feed_byte(wr_idx);
        acc_pend    = pg_in_ready && pg_in_valid;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output int d);
        reg_addr = a;
        #0.5;
        d = int'(reg_rdata);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_page();
        int v;
        for (int i = 0; i < 20000; i++) begin
            rd(4'd2, v);
            if (v[2]) break;
            @(negedge clk);
        end
    endtask

    initial begin
        #(150000 * 5);
        nerr++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        int v, base, nrd, wd, rdl, t, b, last_rd;
        int ek [4];
        int ed [4];
        bit any_rd;
        v = $urandom(32'd2024);
        nrd = 0;
        idle(3);
        rst = 1'b0;
        idle(2);

        // R1 reset state
        chk(nand_we_n && nand_re_n && !nand_cle && !nand_ale && !nand_dq_oe && !irq && !nand_ce_n,
            "R1 pins idle", 0, 1);
        rd(4'd1, v); chk(v == 2, "R1 status", v, 2);
        rd(4'd2, v); chk((v & 6) == 0, "R1 event bits", v & 6, 0);

        // R2/R3/R4 directed
        wr(4'd0, 16'h0210);               // wr_dly 2, rd_dly 1
        base = ev_n;
        wr(4'd4, 16'h0090); wr(4'd5, 16'h0034); wr(4'd6, 16'h00C5);
        idle(30);
        chk(ev_n - base == 3, "R2 event count", ev_n - base, 3);
        chk(ev_kind[base] == 0 && ev_dq[base] == 8'h90 && ev_oe[base] == 1, "R2 command cycle", ev_dq[base], 8'h90);
        chk(ev_kind[base+1] == 1 && ev_dq[base+1] == 8'h34, "R3 address cycle", ev_kind[base+1], 1);
        chk(ev_kind[base+2] == 2 && ev_dq[base+2] == 8'hC5, "R4 data cycle", ev_kind[base+2], 2);
        chk(ev_w[base] == 3, "R6 write width", ev_w[base], 3);

        // R5 full buffer, drop
        wr(4'd0, 16'h0F00);
        base = ev_n;
        for (int k = 0; k < 6; k++) wr(4'd4, 16'(8'hA0 + k));
        rd(4'd1, v); chk((v & 1) == 1, "R5 full flag", v & 1, 1);
        idle(150);
        chk(ev_n - base == 5, "R5 dropped write", ev_n - base, 5);
        for (int k = 0; k < 5; k++)
            chk(ev_dq[base+k] == 8'hA0 + k && ev_w[base+k] == 16, "R5 order", ev_dq[base+k], 8'hA0 + k);
        rd(4'd1, v); chk(v == 2, "R5 drained", v, 2);

        // R7 single read and R8 clear behaviour
        wr(4'd0, 16'h0030);               // rd_dly 3
        base = ev_n;
        wr(4'd7, 16'h1234);
        idle(20);
        chk(ev_n - base == 1 && ev_kind[base] == 3 && ev_oe[base] == 0, "R7 read strobe", ev_kind[base], 3);
        chk(ev_w[base] == 4, "R6 read width", ev_w[base], 4);
        rd(4'd8, v); chk(v == dev_byte(nrd), "R7 read data", v, dev_byte(nrd));
        nrd++;
        rd(4'd2, v); chk(v[1] == 1, "R7 read-ready set", v[1], 1);
        wr(4'd3, 16'h0002); idle(1);
        chk(irq == 1, "R9 masked irq", irq, 1);
        wr(4'd3, 16'h0000); idle(1);
        chk(irq == 0, "R9 zero mask", irq, 0);
        wr(4'd2, 16'h0000); idle(1);
        rd(4'd2, v); chk(v[1] == 1, "R8 write zero keeps", v[1], 1);
        wr(4'd2, 16'h0002); idle(1);
        rd(4'd2, v); chk(v[1] == 0, "R8 write one clears", v[1], 0);
        nand_rb = 1'b0; idle(2);
        rd(4'd2, v); chk(v[0] == 0, "R8 busy pin", v[0], 0);
        nand_rb = 1'b1; idle(2);
        rd(4'd2, v); chk(v[0] == 1, "R8 ready pin", v[0], 1);

        // R13 ecc clear pulse
        reg_wr = 1'b1; reg_addr = 4'd10; reg_wdata = 16'h0001;
        @(negedge clk); reg_wr = 1'b0;
        chk(ecc_clr == 1, "R13 pulse high", ecc_clr, 1);
        @(negedge clk);
        chk(ecc_clr == 0, "R13 pulse one cycle", ecc_clr, 0);

        // random mixed rounds (R2..R7)
        for (int r = 0; r < 12; r++) begin
            wd  = (r == 0) ? 0 : (r == 1) ? 15 : int'($urandom % 16);
            rdl = (r == 0) ? 0 : (r == 1) ? 15 : int'($urandom % 16);
            wr(4'd0, 16'((wd << 8) | (rdl << 4)));
            base = ev_n; any_rd = 0; last_rd = 0;
            for (int k = 0; k < 4; k++) begin
                t = int'($urandom % 4); b = int'($urandom % 256);
                ek[k] = t; ed[k] = b;
                if (t == 3) begin any_rd = 1; last_rd = nrd; nrd++; end
                wr(4'(4 + t), 16'(b));
            end
            idle(100);
            chk(ev_n - base == 4, "R5 random count", ev_n - base, 4);
            for (int k = 0; k < 4; k++) begin
                chk(ev_kind[base+k] == ek[k], "R5 random kind order", ev_kind[base+k], ek[k]);
                chk(ev_w[base+k] == ((ek[k] == 3) ? rdl + 1 : wd + 1), "R6 random width",
                    ev_w[base+k], (ek[k] == 3) ? rdl + 1 : wd + 1);
                if (ek[k] != 3)
                    chk(ev_dq[base+k] == ed[k], "R4 random byte", ev_dq[base+k], ed[k]);
            end
            if (any_rd) begin
                rd(4'd8, v); chk(v == dev_byte(last_rd), "R7 random read data", v, dev_byte(last_rd));
                wr(4'd2, 16'h0002);
            end
        end

        // R11/R12 page read, 256 bytes
        wr(4'd0, 16'h0010);
        base = ev_n; pg_n = 0;
        rd(4'd8, last_rd);
        wr(4'd9, 16'h0001);
        wait_page();
        chk(pg_n == 256, "R12 small page length", pg_n, 256);
        chk(ev_n - base == 256, "R11 read strobes", ev_n - base, 256);
        for (int i = 0; i < 256; i++)
            if (pg_dat[i] != dev_byte(nrd + i)) chk(0, "R11 page byte", pg_dat[i], dev_byte(nrd + i));
        chk(1, "R11 page bytes", 0, 0);
        nrd += 256;
        rd(4'd2, v); chk(v[1] == 0, "R11 read-ready untouched", v[1], 0);
        rd(4'd8, v); chk(v == last_rd, "R11 read data untouched", v, last_rd);
        wr(4'd2, 16'h0004); idle(1);
        rd(4'd2, v); chk(v[2] == 0, "R8 page-done clear", v[2], 0);

        // R12 large page
        wr(4'd0, 16'h0001);
        base = ev_n; pg_n = 0;
        wr(4'd9, 16'h0001);
        wait_page();
        chk(pg_n == 512, "R12 large page length", pg_n, 512);
        chk(pg_dat[511] == dev_byte(nrd + 511), "R11 last byte", pg_dat[511], dev_byte(nrd + 511));
        nrd += 512;
        wr(4'd2, 16'h0004);

        // R10 page write, 256 bytes
        wr(4'd0, 16'h0100);
        base = ev_n; wr_idx = 0;
        pg_feed = 1'b1;
        wr(4'd9, 16'h0002);
        wait_page();
        pg_feed = 1'b0;
        idle(4);
        chk(ev_n - base == 256, "R10 write strobes", ev_n - base, 256);
        for (int i = 0; i < 256; i++)
            if (ev_kind[base+i] != 2 || ev_dq[base+i] != feed_byte(i))
                chk(0, "R10 page write byte", ev_dq[base+i], feed_byte(i));
        chk(1, "R10 page write bytes", 0, 0);
        rd(4'd2, v); chk(v[2] == 1, "R10 page done", v[2], 1);
        rd(4'd1, v); chk(v == 2, "R10 page idle", v, 2);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule